// File: doc/BRIEF.md
# Multiplex Backplane Bank Sequencer

This block steps through the bit columns of a small display memory, one column per multiplex time slot of a segment display driver. The memory holds 32 words of 4 bits; word `a` feeds segment output `a`, and bit `b` of every word belongs to backplane phase `b`. On every slot boundary the sequencer picks the column for the coming phase. It copies that bit from all 32 words at once into a segment latch, which then holds still until the next slot.

The number of phases in one cycle follows the multiplex mode: one, two, three or four. A frame synchronisation input puts the sequence at the last phase of the current mode, so the next slot starts a new cycle at phase 0. Several drivers that share this input therefore run in step. The block only chooses and latches bits. Voltage levels and backplane waveforms are produced elsewhere.

Top module: `bank_sequencer`

## Requirements
- R1: While reset is active and after it is released, `bank_idx` is 0 and `seg_q` is all zeros until the first slot or sync event.
- R2: With `mode` = 2'b11 (four phases), successive `slot_adv` strobes select bank 0, 1, 2, 3 and then 0 again.
- R3: With `mode` = 2'b10 (three phases), successive strobes select bank 0, 1, 2 and then 0 again.
- R4: With `mode` = 2'b01 (two phases), successive strobes alternate between bank 0 and bank 1.
- R5: With `mode` = 2'b00 (static), every strobe selects bank 0.
- R6: A `sync_in` pulse sets `bank_idx` to the last bank of the mode, which is the value of `mode` (3, 2, 1 or 0). The strobe after it selects bank 0.
- R7: When `sync_in` and `slot_adv` are high in the same cycle, the sync result wins and the advance is dropped.
- R8: If `mode` changes so that the current bank is equal to or above the new mode's last bank, the next strobe selects bank 0.
- R9: On each slot or sync event, `seg_q[a]` takes bit `b` of RAM word `a` for all 32 words, where `b` is the bank shown on `bank_idx` after that edge. Word `a` sits at `ram_words[4a+3:4a]`.
- R10: Between events, `seg_q` and `bank_idx` keep their values even when `ram_words` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | Multiplex mode: 0 static, 1 two-phase, 2 three-phase, 3 four-phase |
| slot_adv | input | 1 | One-cycle strobe that starts the next multiplex slot |
| sync_in | input | 1 | Frame synchronisation; moves the sequence to the last bank of the mode |
| ram_words | input | 128 | Display RAM contents, 32 words of 4 bits, word a at bits 4a+3..4a |
| bank_idx | output | 2 | Bank (bit column) selected for the current slot |
| seg_q | output | 32 | Latched segment vector for the current slot |

## Verification
A slot strobe and a sync pulse can arrive in the same clock cycle. The bench raises both together in four-phase mode while the sequence is at bank 1. An advance would give bank 2; the sync alone gives bank 3, and that is the required result. The same edge must also load the segment latch with column 3. One more strobe must then give bank 0, which shows the dropped advance left nothing pending.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int unsigned SEG_COUNT_DEF  = 32;
  localparam int unsigned BANK_COUNT_DEF = 4;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_TWO    = 2'd1,
    MUX_THREE  = 2'd2,
    MUX_FOUR   = 2'd3
  } mux_mode_e;
endpackage

// File: rtl/mbs_rst_sync.sv
module mbs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbs_bank_ctr.sv
module mbs_bank_ctr #(
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] mode,
  input  logic              adv,
  input  logic              sync,
  output logic              evt,
  output logic [BANK_W-1:0] bank_nxt,
  output logic [BANK_W-1:0] bank_q
);
  // next-state: sync wins, else wrap at or beyond the mode's last bank
  always_comb begin
    evt = adv | sync;
    if (sync)                bank_nxt = mode;
    else if (bank_q >= mode) bank_nxt = '0;
    else                     bank_nxt = bank_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bank_q <= '0;
    else if (evt) bank_q <= bank_nxt;
  end
endmodule

// File: rtl/mbs_col_mux.sv
module mbs_col_mux #(
  parameter int unsigned N_SEG  = 32,
  parameter int unsigned N_BANK = 4,
  localparam int unsigned BANK_W = $clog2(N_BANK)
) (
  input  logic [N_SEG*N_BANK-1:0] ram_words,
  input  logic [BANK_W-1:0]       sel,
  output logic [N_SEG-1:0]        col
);
  for (genvar a = 0; a < N_SEG; a++) begin : g_word
    logic [N_BANK-1:0] word;
    assign word   = ram_words[a*N_BANK +: N_BANK];
    assign col[a] = word[sel];
  end
endmodule

// File: rtl/bank_sequencer.sv
module bank_sequencer
  import mbs_pkg::*;
#(
  parameter int unsigned N_SEG  = SEG_COUNT_DEF,
  parameter int unsigned N_BANK = BANK_COUNT_DEF,
  localparam int unsigned BANK_W = $clog2(N_BANK),
  localparam int unsigned RAM_W  = N_SEG * N_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] mode,
  input  logic              slot_adv,
  input  logic              sync_in,
  input  logic [RAM_W-1:0]  ram_words,
  output logic [BANK_W-1:0] bank_idx,
  output logic [N_SEG-1:0]  seg_q
);
  logic              core_rst_n;
  logic              evt;
  logic [BANK_W-1:0] bank_nxt;
  logic [N_SEG-1:0]  col_nxt;

  mbs_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  mbs_bank_ctr #(.BANK_W(BANK_W)) u_ctr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .mode     (mode),
    .adv      (slot_adv),
    .sync     (sync_in),
    .evt      (evt),
    .bank_nxt (bank_nxt),
    .bank_q   (bank_idx)
  );

  // column of the bank being entered, so latch and index agree after the edge
  mbs_col_mux #(.N_SEG(N_SEG), .N_BANK(N_BANK)) u_mux (
    .ram_words (ram_words),
    .sel       (bank_nxt),
    .col       (col_nxt)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) seg_q <= '0;
    else if (evt)    seg_q <= col_nxt;
  end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int unsigned N_SEG  = 32,
  parameter int unsigned N_BANK = 4,
  localparam int unsigned BANK_W = $clog2(N_BANK)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [BANK_W-1:0]       mode,
  input logic                    adv,
  input logic                    sync,
  input logic [N_SEG*N_BANK-1:0] ram_words,
  input logic [BANK_W-1:0]       bank_idx,
  input logic [N_SEG-1:0]        seg_q
);
  logic [N_SEG*N_BANK-1:0] ram_prev;
  logic [N_SEG-1:0]        col_exp;

  always_ff @(posedge clk) ram_prev <= ram_words;

  always_comb begin
    for (int a = 0; a < N_SEG; a++) col_exp[a] = ram_prev[a*N_BANK + int'(bank_idx)];
  end

  AST_STEP_UP:   assert property (@(posedge clk) disable iff (!rst_n) (adv && !sync && bank_idx < mode) |=> bank_idx == BANK_W'($past(bank_idx) + 1'b1)); // R2
  AST_STATIC:    assert property (@(posedge clk) disable iff (!rst_n) (adv && !sync && mode == '0) |=> bank_idx == '0); // R5
  AST_SYNC_LAST: assert property (@(posedge clk) disable iff (!rst_n) sync |=> bank_idx == $past(mode)); // R6
  AST_SYNC_WINS: assert property (@(posedge clk) disable iff (!rst_n) (sync && adv) |=> bank_idx == $past(mode)); // R7
  AST_WRAP:      assert property (@(posedge clk) disable iff (!rst_n) (adv && !sync && bank_idx >= mode) |=> bank_idx == '0); // R8
  AST_COLUMN:    assert property (@(posedge clk) disable iff (!rst_n) (adv || sync) |=> seg_q == col_exp); // R9
  AST_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !(adv || sync) |=> ($stable(seg_q) && $stable(bank_idx))); // R10
endmodule

bind bank_sequencer mbs_checker #(.N_SEG(N_SEG), .N_BANK(N_BANK)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .mode      (mode),
  .adv       (slot_adv),
  .sync      (sync_in),
  .ram_words (ram_words),
  .bank_idx  (bank_idx),
  .seg_q     (seg_q)
);

// File: tb/tb_bank_sequencer.sv
module tb_bank_sequencer;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic         slot_adv;
  logic         sync_in;
  logic [127:0] ram_words;
  logic [1:0]   bank_idx;
  logic [31:0]  seg_q;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bank_sequencer dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .slot_adv(slot_adv),
    .sync_in(sync_in), .ram_words(ram_words), .bank_idx(bank_idx), .seg_q(seg_q)
  );

  function automatic logic [127:0] make_ram(input int seed);
    logic [127:0] r;
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 4; b++)
        r[a*4+b] = (((a*5 + b*3 + seed) % 7) < 3);
    return r;
  endfunction

  function automatic logic [31:0] col_of(input logic [127:0] r, input int b);
    logic [31:0] c;
    for (int a = 0; a < 32; a++) c[a] = r[a*4+b];
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one event, checked at the falling edge after it
  task automatic step(input logic adv, input logic syn, input string req, input int exp_bank);
    @(negedge clk);
    slot_adv = adv; sync_in = syn;
    @(negedge clk);
    slot_adv = 1'b0; sync_in = 1'b0;
    check(req, 32'(bank_idx), 32'(exp_bank));
    check(req, seg_q, col_of(ram_words, exp_bank));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mode = 2'd3; slot_adv = 1'b0; sync_in = 1'b0;
    ram_words = make_ram(1);
    repeat (3) @(negedge clk);
    check("R1 during reset", 32'(bank_idx), 0);
    check("R1 during reset", seg_q, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 32'(bank_idx), 0);
    check("R1 after release", seg_q, 0);
  endtask

  // sync, then five strobes; exp packs six banks, first in the low bits
  task automatic t_seq(input logic [1:0] m, input logic [11:0] exp, input string req);
    mode = m;
    step(1'b0, 1'b1, "R6 sync to last", int'(exp[1:0]));
    for (int i = 1; i < 6; i++) step(1'b1, 1'b0, req, int'(exp[i*2 +: 2]));
  endtask

  task automatic t_sync_prio();
    mode = 2'd3;
    step(1'b0, 1'b1, "R6", 3);
    step(1'b1, 1'b0, "R2", 0);
    step(1'b1, 1'b0, "R2", 1);
    step(1'b1, 1'b1, "R7 sync wins", 3);
    step(1'b1, 1'b0, "R7 next after sync", 0);
  endtask

  task automatic t_mode_change();
    mode = 2'd3;
    step(1'b0, 1'b1, "R6", 3);
    mode = 2'd1;
    step(1'b1, 1'b0, "R8 wrap from 3", 0);
    step(1'b1, 1'b0, "R8", 1);
    mode = 2'd3;
    step(1'b1, 1'b0, "R8 widen", 2);
    mode = 2'd2;
    step(1'b1, 1'b0, "R8 wrap at last", 0);
  endtask

  task automatic t_hold();
    logic [31:0] held;
    logic [1:0]  hb;
    mode = 2'd3;
    step(1'b1, 1'b0, "R9", 1);
    held = seg_q; hb = bank_idx;
    ram_words = ~ram_words;
    repeat (3) @(negedge clk);
    check("R10 seg held", seg_q, held);
    check("R10 bank held", 32'(bank_idx), 32'(hb));
    step(1'b1, 1'b0, "R9 new contents", 2);
    ram_words = make_ram(4);
    step(1'b0, 1'b1, "R9 on sync", 3);
  endtask

  initial begin
    t_reset();
    t_seq(2'd3, {2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3}, "R2 four-phase");
    ram_words = make_ram(2);
    t_seq(2'd2, {2'd1, 2'd0, 2'd2, 2'd1, 2'd0, 2'd2}, "R3 three-phase");
    ram_words = make_ram(3);
    t_seq(2'd1, {2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd1}, "R4 two-phase");
    t_seq(2'd0, {2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0}, "R5 static");
    t_sync_prio();
    t_mode_change();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule